// File: doc/BRIEF.md
# Precise Pipeline Exception Controller

This block is the exception control for a five-stage in-order pipeline. Each cycle it receives a valid bit, a PC and one fault flag from each of the fetch, decode, execute and memory stages. It finds the oldest valid faulting instruction, which is the one furthest down the pipeline. In the same cycle it turns that instruction and every younger instruction into bubbles, and it suppresses the register write of an overflowing execute-stage instruction and the memory write of a faulting memory-stage access. At the clock edge it stores the faulting PC plus 4 and a 2-bit cause code. During the next cycle it steers fetch to the fixed handler vector.

An exception-return request steers fetch, in the following cycle, to the saved PC minus 4, so that the faulting instruction is fetched again. A small state machine owns the redirect and has three states. RUN means there is no redirect. VECTOR means fetch goes to the handler. RESUME means fetch goes to the saved PC minus 4. The state is picked from the inputs every cycle. Transition TAKE enters VECTOR on any accepted exception. Transition RETURN enters RESUME on a return request when no exception is accepted. Transition SETTLE enters RUN otherwise. All three transitions can start from any state.

Top module: `trap_ctrl`

## Requirements
- R1: When an exception is taken, `epc` holds the faulting instruction's PC plus 4 from the next cycle on.
- R2: When an exception is taken, `cause` is loaded by stage: decode illegal opcode = 0, execute overflow = 1, memory-stage page fault = 2, fetch fault = 3.
- R3: In the cycle after an exception is taken, `redirect_valid` is 1 and `redirect_pc` is 0x8000_0180. `redirect_valid` is 0 in any cycle that follows a cycle with neither an exception nor a return.
- R4: In the cycle an exception is taken, `squash` marks the faulting stage and every younger stage. Older stages are not marked. The bit order is: bit 0 fetch, bit 1 decode, bit 2 execute, bit 3 memory.
- R5: `reg_wr_kill` is 1 whenever a valid execute instruction overflows or any older fault squashes the execute stage. `mem_wr_kill` is 1 exactly when the memory stage is squashed.
- R6: When several valid stages fault in the same cycle, the stage furthest along the pipeline wins. It decides `epc`, `cause` and `squash`.
- R7: A fault flag from a stage whose valid bit is 0 has no effect on `squash`, the kills, `epc`, `cause` or the redirect.
- R8: `epc` and `cause` keep their values in every cycle in which no exception is taken.
- R9: A return request with no exception in the same cycle gives `redirect_valid` = 1 and `redirect_pc` = `epc` − 4 in the next cycle.
- R10: When an exception and a return request arrive in the same cycle, the exception wins. The next redirect goes to the handler vector and `epc` takes the new value.
- R11: After reset, `epc` and `cause` are 0, `redirect_valid` is 0, and `squash` is 0 while no stage faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_valid | input | 1 | Fetch stage holds a real instruction |
| if_pc | input | 32 | Fetch stage PC |
| if_fault | input | 1 | Fetch fault flag |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_pc | input | 32 | Decode stage PC |
| id_illegal | input | 1 | Undefined opcode flag |
| ex_valid | input | 1 | Execute stage holds a real instruction |
| ex_pc | input | 32 | Execute stage PC |
| ex_ovf | input | 1 | Arithmetic overflow flag |
| mem_valid | input | 1 | Memory stage holds a real instruction |
| mem_pc | input | 32 | Memory stage PC |
| mem_fault | input | 1 | Load/store page fault flag |
| xret | input | 1 | Exception-return request |
| squash | output | 4 | Per-stage bubble request (bit 0 fetch … bit 3 memory) |
| reg_wr_kill | output | 1 | Suppress the execute instruction's register write |
| mem_wr_kill | output | 1 | Suppress the memory stage's store |
| epc | output | 32 | Saved exception PC (faulting PC + 4) |
| cause | output | 2 | Saved cause code |
| redirect_valid | output | 1 | Fetch must load `redirect_pc` |
| redirect_pc | output | 32 | Next fetch address |

## Verification
Two pairs of functions can fall in the same cycle. The first is several stages faulting together, for example a memory page fault alongside an execute overflow. The second is an exception arriving in the same cycle as a return request. Both are driven in directed cycles and also appear often in a random stream of stage flags and valid bits. A behavioural model in the bench picks the oldest valid fault, tracks the saved PC and cause, and predicts the redirect. It is compared with the squash and kill outputs within the cycle, and with the registered outputs after each edge.

// File: rtl/trap_pkg.sv
package trap_pkg;
    localparam int NSTAGE  = 4;
    localparam int CAUSE_W = 2;

    localparam int STG_FETCH = 0;
    localparam int STG_DEC   = 1;
    localparam int STG_EXE   = 2;
    localparam int STG_MEM   = 3;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_VECTOR = 2'd1,
        ST_RESUME = 2'd2
    } trap_state_t;

    function automatic logic [CAUSE_W-1:0] stage_cause(input int stg);
        logic [CAUSE_W-1:0] c;
        case (stg)
            STG_DEC: c = CAUSE_W'(0);
            STG_EXE: c = CAUSE_W'(1);
            STG_MEM: c = CAUSE_W'(2);
            default: c = CAUSE_W'(3);
        endcase
        return c;
    endfunction
endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
    import trap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NSTAGE-1:0]              stg_valid,
    input  logic [NSTAGE-1:0]              stg_flag,
    input  logic [NSTAGE-1:0][XLEN-1:0]    stg_pc,
    output logic                           take,
    output logic [NSTAGE-1:0]              squash,
    output logic [XLEN-1:0]                win_pc,
    output logic [CAUSE_W-1:0]             win_cause
);
    logic [NSTAGE-1:0] live;
    logic [NSTAGE-1:0] win_onehot;

    assign live = stg_valid & stg_flag;
    assign take = |live;

    // Higher index = older instruction.
    for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
        if (s == NSTAGE - 1) begin : g_top
            assign win_onehot[s] = live[s];
        end else begin : g_rest
            assign win_onehot[s] = live[s] & ~(|live[NSTAGE-1:s+1]);
        end
        assign squash[s] = |live[NSTAGE-1:s];
    end

    always_comb begin
        win_pc    = '0;
        win_cause = '0;
        for (int s = 0; s < NSTAGE; s++) begin
            if (win_onehot[s]) begin
                win_pc    = stg_pc[s];
                win_cause = stage_cause(s);
            end
        end
    end

    // R6: the memory stage outranks everything when it faults
    p_oldest_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stg_valid[STG_MEM] && stg_flag[STG_MEM]) |-> (win_cause == CAUSE_W'(2) && win_pc == stg_pc[STG_MEM]));

    // R7: masked flags never cause a squash
    p_bubble_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((stg_valid & stg_flag) == '0) |-> (squash == '0));

    // R4: a winner in the fetch stage only squashes fetch
    p_fetch_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && win_cause == CAUSE_W'(3)) |-> (squash == NSTAGE'(1)));
endmodule

// File: rtl/trap_regs.sv
module trap_regs
    import trap_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int PC_STEP = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take,
    input  logic [XLEN-1:0]    win_pc,
    input  logic [CAUSE_W-1:0] win_cause,
    output logic [XLEN-1:0]    epc,
    output logic [CAUSE_W-1:0] cause
);
    localparam logic [XLEN-1:0] STEP_V = XLEN'(PC_STEP);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc   <= '0;
            cause <= '0;
        end else if (take) begin
            epc   <= win_pc + STEP_V;
            cause <= win_cause;
        end
    end

    // R1: saved PC is the faulting PC plus one instruction
    p_epc_r1: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (epc == $past(win_pc) + STEP_V));

    // R8: no exception, no change
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> ($stable(epc) && $stable(cause)));
endmodule

// File: rtl/trap_fsm.sv
module trap_fsm
    import trap_pkg::*;
#(
    parameter int              XLEN        = 32,
    parameter int              PC_STEP     = 4,
    parameter logic [XLEN-1:0] HANDLER_VEC = 32'h8000_0180
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    input  logic            xret,
    input  logic [XLEN-1:0] epc,
    output logic            redirect_valid,
    output logic [XLEN-1:0] redirect_pc
);
    localparam logic [XLEN-1:0] STEP_V = XLEN'(PC_STEP);

    trap_state_t state, state_nx;

    always_comb begin
        if (take)      state_nx = ST_VECTOR;   // TAKE
        else if (xret) state_nx = ST_RESUME;   // RETURN
        else           state_nx = ST_RUN;      // SETTLE
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            ST_VECTOR: begin
                redirect_valid = 1'b1;
                redirect_pc    = HANDLER_VEC;
            end
            ST_RESUME: begin
                redirect_valid = 1'b1;
                redirect_pc    = epc - STEP_V;
            end
            default: begin
                redirect_valid = 1'b0;
                redirect_pc    = '0;
            end
        endcase
    end

    // R3: handler vector one cycle after an exception
    p_vector_r3: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (redirect_valid && redirect_pc == HANDLER_VEC));

    // R9: return steers to saved PC minus one instruction
    p_resume_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (xret && !take) |=> (redirect_valid && redirect_pc == $past(epc) - STEP_V));

    // R10: exception beats a simultaneous return
    p_trap_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (xret && take) |=> (redirect_pc == HANDLER_VEC));

    // R3: quiet cycle gives no redirect
    p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!xret && !take) |=> !redirect_valid);
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
    import trap_pkg::*;
#(
    parameter int              XLEN        = 32,
    parameter int              PC_STEP     = 4,
    parameter logic [XLEN-1:0] HANDLER_VEC = 32'h8000_0180
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               if_valid,
    input  logic [XLEN-1:0]    if_pc,
    input  logic               if_fault,
    input  logic               id_valid,
    input  logic [XLEN-1:0]    id_pc,
    input  logic               id_illegal,
    input  logic               ex_valid,
    input  logic [XLEN-1:0]    ex_pc,
    input  logic               ex_ovf,
    input  logic               mem_valid,
    input  logic [XLEN-1:0]    mem_pc,
    input  logic               mem_fault,
    input  logic               xret,
    output logic [NSTAGE-1:0]  squash,
    output logic               reg_wr_kill,
    output logic               mem_wr_kill,
    output logic [XLEN-1:0]    epc,
    output logic [CAUSE_W-1:0] cause,
    output logic               redirect_valid,
    output logic [XLEN-1:0]    redirect_pc
);
    logic [NSTAGE-1:0]           stg_valid;
    logic [NSTAGE-1:0]           stg_flag;
    logic [NSTAGE-1:0][XLEN-1:0] stg_pc;
    logic                        take;
    logic [XLEN-1:0]             win_pc;
    logic [CAUSE_W-1:0]          win_cause;

    assign stg_valid = {mem_valid, ex_valid, id_valid, if_valid};
    assign stg_flag  = {mem_fault, ex_ovf, id_illegal, if_fault};
    assign stg_pc    = {mem_pc, ex_pc, id_pc, if_pc};

    trap_arbiter #(.XLEN(XLEN)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .stg_valid (stg_valid),
        .stg_flag  (stg_flag),
        .stg_pc    (stg_pc),
        .take      (take),
        .squash    (squash),
        .win_pc    (win_pc),
        .win_cause (win_cause)
    );

    assign reg_wr_kill = squash[STG_EXE];
    assign mem_wr_kill = squash[STG_MEM];

    trap_regs #(.XLEN(XLEN), .PC_STEP(PC_STEP)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .win_pc    (win_pc),
        .win_cause (win_cause),
        .epc       (epc),
        .cause     (cause)
    );

    trap_fsm #(.XLEN(XLEN), .PC_STEP(PC_STEP), .HANDLER_VEC(HANDLER_VEC)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .take           (take),
        .xret           (xret),
        .epc            (epc),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc)
    );

    // R5: an overflowing add never writes its destination
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && ex_ovf) |-> reg_wr_kill);

    // R5: a faulting memory access never stores
    p_mem_kill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_fault) |-> mem_wr_kill);

    // R4: an older, clean memory instruction completes past an execute fault
    p_older_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && ex_ovf && !(mem_valid && mem_fault)) |-> (!mem_wr_kill && squash[STG_FETCH]));
endmodule

// File: tb/trap_ctrl_bench.sv
module trap_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  vv = '0;
    logic [3:0]  ff = '0;
    logic [31:0] pcs [4];
    logic        xr = 1'b0;

    logic [3:0]  squash;
    logic        reg_wr_kill, mem_wr_kill, redirect_valid;
    logic [31:0] epc, redirect_pc;
    logic [1:0]  cause;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_epc = '0;
    logic [1:0]  m_cause = '0;
    logic        m_rv = 1'b0;
    logic [31:0] m_rpc = '0;

    always #4 clk = ~clk;

    trap_ctrl u_trap_ctrl (
        .clk(clk), .rst_n(rst_n),
        .if_valid(vv[0]),  .if_pc(pcs[0]),  .if_fault(ff[0]),
        .id_valid(vv[1]),  .id_pc(pcs[1]),  .id_illegal(ff[1]),
        .ex_valid(vv[2]),  .ex_pc(pcs[2]),  .ex_ovf(ff[2]),
        .mem_valid(vv[3]), .mem_pc(pcs[3]), .mem_fault(ff[3]),
        .xret(xr),
        .squash(squash), .reg_wr_kill(reg_wr_kill), .mem_wr_kill(mem_wr_kill),
        .epc(epc), .cause(cause),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] code_of(input int s);
        if (s == 3) return 2'd2;   // memory page fault
        if (s == 2) return 2'd1;   // overflow
        if (s == 1) return 2'd0;   // illegal opcode
        return 2'd3;               // fetch fault
    endfunction

    // Drive one cycle at the falling edge, check combinational and registered results.
    task automatic step(input logic [3:0] v, input logic [3:0] f, input logic x, input logic [31:0] base);
        int win = -1;
        int nfault = 0;
        logic [3:0] esq = '0;
        logic [31:0] n_epc;
        logic [1:0]  n_cause;
        logic        n_rv;
        logic [31:0] n_rpc;
        string tag;
        vv = v; ff = f; xr = x;
        for (int s = 0; s < 4; s++) pcs[s] = base + 32'(4 * (3 - s));
        #1;
        for (int s = 3; s >= 0; s--) begin
            if (v[s] && f[s]) begin
                nfault++;
                if (win < 0) win = s;
            end
        end
        for (int s = 0; s < 4; s++) if (win >= 0 && s <= win) esq[s] = 1'b1;
        if (nfault > 1) tag = "R6 squash";
        else if ((f & ~v) != 0) tag = "R7 squash";
        else tag = "R4 squash";
        chk(tag, 32'(squash), 32'(esq));
        chk("R5 reg_wr_kill", 32'(reg_wr_kill), 32'(esq[2]));
        chk("R5 mem_wr_kill", 32'(mem_wr_kill), 32'(esq[3]));
        n_epc = m_epc; n_cause = m_cause;
        if (win >= 0) begin
            n_epc = pcs[win] + 32'd4; n_cause = code_of(win);
            n_rv = 1'b1; n_rpc = 32'h8000_0180;
        end else if (x) begin
            n_rv = 1'b1; n_rpc = m_epc - 32'd4;
        end else begin
            n_rv = 1'b0; n_rpc = '0;
        end
        @(posedge clk);
        m_epc = n_epc; m_cause = n_cause; m_rv = n_rv; m_rpc = n_rpc;
        @(negedge clk);
        chk(win >= 0 ? "R1 epc" : "R8 epc hold", epc, m_epc);
        chk(win >= 0 ? "R2 cause" : "R8 cause hold", 32'(cause), 32'(m_cause));
        if (win >= 0 && x) tag = "R10 redirect";
        else if (win >= 0) tag = "R3 redirect";
        else if (x) tag = "R9 redirect";
        else tag = "R3 no redirect";
        chk(tag, 32'(redirect_valid), 32'(m_rv));
        if (m_rv) chk(tag, redirect_pc, m_rpc);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int s = 0; s < 4; s++) pcs[s] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R11 epc", epc, 32'h0);
        chk("R11 cause", 32'(cause), 32'h0);
        chk("R11 redirect_valid", 32'(redirect_valid), 32'h0);
        chk("R11 squash", 32'(squash), 32'h0);
        @(negedge clk);
        step(4'b1111, 4'b0010, 1'b0, 32'h0000_1000); // R2 illegal opcode
        step(4'b1111, 4'b0100, 1'b0, 32'h0000_2000); // R5 overflow
        step(4'b1111, 4'b1100, 1'b0, 32'h0000_3000); // R6 mem beats ex
        step(4'b1111, 4'b0001, 1'b0, 32'h0000_4000); // R2 fetch fault
        step(4'b0000, 4'b1111, 1'b0, 32'h0000_5000); // R7 all masked
        step(4'b0111, 4'b1100, 1'b0, 32'h0000_6000); // R7 masked mem, ex wins
        step(4'b1111, 4'b0000, 1'b0, 32'h0000_7000); // R8 hold
        step(4'b1111, 4'b0000, 1'b1, 32'h0000_8000); // R9 return
        step(4'b1111, 4'b0010, 1'b1, 32'h0000_9000); // R10 trap beats return
        step(4'b1111, 4'b1111, 1'b0, 32'h0000_A000); // R6 all fault
        step(4'b1111, 4'b0000, 1'b1, 32'h0000_B000); // R9 return again
        for (int i = 0; i < 600; i++) begin
            logic [3:0] rv, rf;
            rv = 4'($urandom);
            rf = 4'($urandom) & 4'($urandom);
            step(rv, rf, 1'($urandom % 4 == 0), {$urandom} & 32'hFFFF_FFF0);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule